// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page mappings. It looks up a 20-bit virtual page number against every stored mapping in parallel. On a hit it returns the physical page number and the permission bits in the same cycle, with no clock edge in between. A miss raises a request, with the page number, to an external page table walker. The walker later presents the resolved mapping on the fill port, and the requester then retries the lookup.

A fill may land in any entry. The block first picks the lowest-numbered empty entry. When no entry is empty, it picks the entry used least recently. A hit and a fill both count as a use. The contents stay coherent in two ways. A change of the page table base clears the whole buffer in one cycle. When software changes one mapping, an invalidate port removes that single page. The buffer follows a no-write policy. A lookup never changes a stored entry, and nothing is ever written back to the page tables. A store to a clean page therefore misses, so that the walker can mark the page dirty and refill it.

Top module: `xlt_buffer`

## Requirements
- R1: After reset every entry is empty, so every lookup misses until a fill arrives.
- R2: A lookup with `lk_valid` high that hits reports `lk_hit`, the stored physical page and the stored read/write/execute/dirty bits combinationally, in the same cycle. On a miss these outputs read zero.
- R3: `walk_req` is high exactly when `lk_valid` is high and `lk_hit` is low. `walk_vpn` always equals `lk_vpn`.
- R4: A fill is written at the clock edge that ends its cycle. A lookup of that page in the same cycle still misses, and a lookup in the next cycle hits.
- R5: A fill for a page that is already held overwrites that entry in place. The buffer never holds two entries that match one page.
- R6: A fill for a new page goes to the lowest-indexed empty entry. When all entries are full, it replaces the least recently used entry, where a hitting lookup and a fill each count as a use.
- R7: A store lookup (`lk_kind` 01) that matches an entry whose write bit is set and whose dirty bit is clear is treated as a miss.
- R8: `lk_kind` encodes 00 load, 01 store, 10 instruction fetch, and 11 behaves as a load. A hit whose access type has its permission bit clear (read, write or execute) raises `lk_fault` together with `lk_hit` and makes no walk request. A store to an entry with the write bit clear faults whatever its dirty bit is.
- R9: `base_chg` empties every entry at the next edge. A fill in the same cycle is discarded.
- R10: `inv_valid` empties only the entry matching `inv_vpn`. An invalidate for a page that is not held changes nothing.
- R11: Lookups never modify entries. A store that hits does not alter the stored bits, and a dirty miss stays a miss until a fill arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_kind | input | 2 | Access type: 00 load, 01 store, 10 fetch, 11 load |
| lk_hit | output | 1 | Translation found and usable |
| lk_fault | output | 1 | Hit with the access type not permitted |
| lk_ppn | output | 20 | Physical page number on hit |
| lk_rd | output | 1 | Stored read permission on hit |
| lk_wr | output | 1 | Stored write permission on hit |
| lk_ex | output | 1 | Stored execute permission on hit |
| lk_dirty | output | 1 | Stored dirty bit on hit |
| walk_req | output | 1 | Page table walk needed |
| walk_vpn | output | 20 | Page the walker must resolve |
| fill_valid | input | 1 | Walker result present |
| fill_vpn | input | 20 | Virtual page of the result |
| fill_ppn | input | 20 | Physical page of the result |
| fill_rd | input | 1 | Read permission of the result |
| fill_wr | input | 1 | Write permission of the result |
| fill_ex | input | 1 | Execute permission of the result |
| fill_dirty | input | 1 | Dirty bit of the result |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page to invalidate |
| base_chg | input | 1 | Page table base changed: flush all |

## Verification
A stale valid bit left by a flush or an invalidate shows up on the very next lookup of that page as a hit where a miss is due. A wrong tag or page number shows up at once as a wrong `lk_ppn`. A corrupted recency order stays invisible until the buffer is full and a fill evicts the wrong page. That can be many cycles later, so the bench fills to capacity, steers the use order deliberately and then probes every known page after each eviction. Permission and dirty-bit faults appear in the same cycle as the lookup, so every stored entry is probed with all four access codes.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_ALT   = 2'b11
   } xlt_acc_e;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
      logic d;
   } xlt_perm_t;

endpackage

// File: rtl/xlt_match.sv
module xlt_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20
) (
   input  logic [ENTRIES-1:0]            vld,
   input  logic [ENTRIES-1:0][VPN_W-1:0] tag,
   input  logic [VPN_W-1:0]              key,
   output logic [ENTRIES-1:0]            hit
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit[i] = vld[i] && (tag[i] == key);
   end
endmodule

// File: rtl/xlt_store.sv
module xlt_store
   import xlt_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic [ENTRIES-1:0]            wr_oh,
   input  logic [VPN_W-1:0]              wr_tag,
   input  logic [PPN_W-1:0]              wr_ppn,
   input  xlt_perm_t                     wr_perm,
   input  logic [ENTRIES-1:0]            clr_oh,
   output logic [ENTRIES-1:0]            vld,
   output logic [ENTRIES-1:0][VPN_W-1:0] tag,
   output logic [ENTRIES-1:0][PPN_W-1:0] ppn,
   output xlt_perm_t [ENTRIES-1:0]       perm
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic             v_q;
      logic [VPN_W-1:0] t_q;
      logic [PPN_W-1:0] p_q;
      xlt_perm_t        a_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
            p_q <= '0;
            a_q <= '0;
         end else if (flush) begin
            v_q <= 1'b0;
         end else if (wr_oh[i]) begin
            v_q <= 1'b1;
            t_q <= wr_tag;
            p_q <= wr_ppn;
            a_q <= wr_perm;
         end else if (clr_oh[i]) begin
            v_q <= 1'b0;
         end
      end

      assign vld[i]  = v_q;
      assign tag[i]  = t_q;
      assign ppn[i]  = p_q;
      assign perm[i] = a_q;
   end
endmodule

// File: rtl/xlt_lru.sv
module xlt_lru #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ta_v,
   input  logic [IDX_W-1:0]   ta_idx,
   input  logic               tb_v,
   input  logic [IDX_W-1:0]   tb_idx,
   input  logic [ENTRIES-1:0] vld,
   output logic [IDX_W-1:0]   victim
);
   // age[i][j] set: entry i was used after entry j
   logic [ENTRIES-1:0][ENTRIES-1:0] age, age_n;

   always_comb begin
      age_n = age;
      if (ta_v) begin
         for (int j = 0; j < ENTRIES; j++) begin
            age_n[ta_idx][j] = 1'b1;
            age_n[j][ta_idx] = 1'b0;
         end
         age_n[ta_idx][ta_idx] = 1'b0;
      end
      if (tb_v) begin
         for (int j = 0; j < ENTRIES; j++) begin
            age_n[tb_idx][j] = 1'b1;
            age_n[j][tb_idx] = 1'b0;
         end
         age_n[tb_idx][tb_idx] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++)
            for (int j = 0; j < ENTRIES; j++)
               age[i][j] <= (i > j);
      end else begin
         age <= age_n;
      end
   end

   always_comb begin
      victim = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (age[i] == '0) victim = IDX_W'(i);
      if (!(&vld)) begin
         for (int i = ENTRIES - 1; i >= 0; i--)
            if (!vld[i]) victim = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xlt_buffer.sv
module xlt_buffer
   import xlt_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [1:0]       lk_kind,
   output logic             lk_hit,
   output logic             lk_fault,
   output logic [PPN_W-1:0] lk_ppn,
   output logic             lk_rd,
   output logic             lk_wr,
   output logic             lk_ex,
   output logic             lk_dirty,
   output logic             walk_req,
   output logic [VPN_W-1:0] walk_vpn,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_rd,
   input  logic             fill_wr,
   input  logic             fill_ex,
   input  logic             fill_dirty,
   input  logic             inv_valid,
   input  logic [VPN_W-1:0] inv_vpn,
   input  logic             base_chg
);
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlt_buffer: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("xlt_buffer: page number widths must be positive");
   end

   logic [ENTRIES-1:0]            vld_vec;
   logic [ENTRIES-1:0][VPN_W-1:0] tag_arr;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr;
   xlt_perm_t [ENTRIES-1:0]       perm_arr;
   logic [ENTRIES-1:0]            lk_m, fl_m, iv_m;
   logic [ENTRIES-1:0]            wr_oh, clr_oh;
   logic [IDX_W-1:0]              lk_idx, fl_idx, victim, fill_idx;
   logic [PPN_W-1:0]              sel_ppn;
   xlt_perm_t                     sel_perm, fill_perm;
   xlt_acc_e                      kind;
   logic                          any_m, dirty_miss, allowed, do_fill;

   xlt_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_m_lk (
      .vld(vld_vec), .tag(tag_arr), .key(lk_vpn), .hit(lk_m));
   xlt_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_m_fl (
      .vld(vld_vec), .tag(tag_arr), .key(fill_vpn), .hit(fl_m));
   xlt_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_m_iv (
      .vld(vld_vec), .tag(tag_arr), .key(inv_vpn), .hit(iv_m));

   // one-hot AND-OR selection of the matching entry
   always_comb begin
      sel_ppn  = '0;
      sel_perm = '0;
      lk_idx   = '0;
      fl_idx   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         sel_ppn  = sel_ppn  | (lk_m[i] ? ppn_arr[i]  : '0);
         sel_perm = sel_perm | (lk_m[i] ? perm_arr[i] : '0);
         lk_idx   = lk_idx   | (lk_m[i] ? IDX_W'(i)   : '0);
         fl_idx   = fl_idx   | (fl_m[i] ? IDX_W'(i)   : '0);
      end
   end

   assign kind       = xlt_acc_e'(lk_kind);
   assign any_m      = |lk_m;
   assign dirty_miss = (kind == ACC_STORE) && sel_perm.w && !sel_perm.d;

   always_comb begin
      unique case (kind)
         ACC_STORE: allowed = sel_perm.w;
         ACC_FETCH: allowed = sel_perm.x;
         default:   allowed = sel_perm.r;
      endcase
   end

   assign lk_hit   = lk_valid && any_m && !dirty_miss;
   assign lk_fault = lk_hit && !allowed;
   assign lk_ppn   = lk_hit ? sel_ppn    : '0;
   assign lk_rd    = lk_hit && sel_perm.r;
   assign lk_wr    = lk_hit && sel_perm.w;
   assign lk_ex    = lk_hit && sel_perm.x;
   assign lk_dirty = lk_hit && sel_perm.d;
   assign walk_req = lk_valid && !lk_hit;
   assign walk_vpn = lk_vpn;

   // fill placement: existing page in place, else replacement choice
   assign do_fill  = fill_valid && !base_chg;
   assign fill_idx = (|fl_m) ? fl_idx : victim;
   assign fill_perm = '{r: fill_rd, w: fill_wr, x: fill_ex, d: fill_dirty};

   always_comb begin
      wr_oh = '0;
      if (do_fill) wr_oh[fill_idx] = 1'b1;
   end
   assign clr_oh = inv_valid ? iv_m : '0;

   xlt_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(base_chg),
      .wr_oh(wr_oh), .wr_tag(fill_vpn), .wr_ppn(fill_ppn), .wr_perm(fill_perm),
      .clr_oh(clr_oh),
      .vld(vld_vec), .tag(tag_arr), .ppn(ppn_arr), .perm(perm_arr));

   xlt_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .ta_v(lk_hit), .ta_idx(lk_idx),
      .tb_v(do_fill), .tb_idx(fill_idx),
      .vld(vld_vec), .victim(victim));
endmodule

// File: rtl/xlt_buffer_chk.sv
module xlt_buffer_chk #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [VPN_W-1:0]   lk_vpn,
   input logic               lk_hit,
   input logic               lk_fault,
   input logic               walk_req,
   input logic               fill_valid,
   input logic               inv_valid,
   input logic [VPN_W-1:0]   inv_vpn,
   input logic               base_chg,
   input logic [ENTRIES-1:0] lk_m,
   input logic [ENTRIES-1:0] vld_vec
);
   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_m)); // R5

   AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (walk_req != lk_hit)); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!walk_req && !lk_hit)); // R3

   AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> (lk_hit && !walk_req)); // R8

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      base_chg |=> (vld_vec == '0)); // R9

   AST_INV_GONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !fill_valid) |=> !(lk_valid && lk_hit && lk_vpn == $past(inv_vpn))); // R10

   AST_LOOKUP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fill_valid && !inv_valid && !base_chg) |=> $stable(vld_vec)); // R11
endmodule

bind xlt_buffer xlt_buffer_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
   .lk_hit(lk_hit), .lk_fault(lk_fault), .walk_req(walk_req),
   .fill_valid(fill_valid), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
   .base_chg(base_chg), .lk_m(lk_m), .vld_vec(vld_vec));

// File: tb/sim_xlt_buffer.sv
module sim_xlt_buffer;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [1:0]  lk_kind = '0;
   logic        lk_hit, lk_fault, lk_rd, lk_wr, lk_ex, lk_dirty, walk_req;
   logic [19:0] lk_ppn, walk_vpn;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0, fill_ppn = '0;
   logic        fill_rd = 1'b0, fill_wr = 1'b0, fill_ex = 1'b0, fill_dirty = 1'b0;
   logic        inv_valid = 1'b0;
   logic [19:0] inv_vpn = '0;
   logic        base_chg = 1'b0;

   always #2 clk = ~clk;

   xlt_buffer u0 (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_kind(lk_kind),
      .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_ppn(lk_ppn), .lk_rd(lk_rd), .lk_wr(lk_wr),
      .lk_ex(lk_ex), .lk_dirty(lk_dirty), .walk_req(walk_req), .walk_vpn(walk_vpn),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd),
      .fill_wr(fill_wr), .fill_ex(fill_ex), .fill_dirty(fill_dirty),
      .inv_valid(inv_valid), .inv_vpn(inv_vpn), .base_chg(base_chg));

   int checks = 0;
   int errors = 0;

   // bench model: entries with {r,w,x,d} and a use stamp
   logic        m_v  [N];
   logic [19:0] m_tag[N];
   logic [19:0] m_ppn[N];
   logic [3:0]  m_p  [N];
   longint      m_st [N];
   longint      now = 0;
   logic [19:0] known[$];

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int mfind(input logic [19:0] v);
      for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == v) return i;
      return -1;
   endfunction

   function automatic int mvictim();
      int b;
      for (int i = 0; i < N; i++) if (!m_v[i]) return i;
      b = 0;
      for (int i = 1; i < N; i++) if (m_st[i] < m_st[b]) b = i;
      return b;
   endfunction

   task automatic idle();
      lk_valid = 0; fill_valid = 0; inv_valid = 0; base_chg = 0;
   endtask

   task automatic look(input logic [19:0] v, input logic [1:0] k, input string req);
      int idx;
      logic h, f;
      logic [3:0] p;
      logic [63:0] exp, act;
      idx = mfind(v);
      h = 0; f = 0; p = '0;
      if (idx >= 0) begin
         p = m_p[idx];
         if (!(k == 2'b01 && p[2] && !p[0])) begin
            h = 1;
            f = (k == 2'b01) ? !p[2] : (k == 2'b10) ? !p[1] : !p[3];
         end
      end
      exp = {17'd0, h, f, !h, v, (h ? m_ppn[idx] : 20'd0), (h ? p : 4'd0)};
      @(negedge clk);
      lk_valid = 1; lk_vpn = v; lk_kind = k;
      #1;
      act = {17'd0, lk_hit, lk_fault, walk_req, walk_vpn, lk_ppn, lk_rd, lk_wr, lk_ex, lk_dirty};
      check(act == exp, req, act, exp);
      @(posedge clk);
      if (h) m_st[idx] = ++now;
      #1 idle();
   endtask

   task automatic fill(input logic [19:0] v, input logic [19:0] pp, input logic [3:0] p);
      int idx;
      @(negedge clk);
      fill_valid = 1; fill_vpn = v; fill_ppn = pp;
      {fill_rd, fill_wr, fill_ex, fill_dirty} = p;
      @(posedge clk);
      idx = mfind(v);
      if (idx < 0) idx = mvictim();
      m_v[idx] = 1; m_tag[idx] = v; m_ppn[idx] = pp; m_p[idx] = p; m_st[idx] = ++now;
      if (!(v inside {known})) known.push_back(v);
      #1 idle();
   endtask

   task automatic inval(input logic [19:0] v);
      int idx;
      @(negedge clk);
      inv_valid = 1; inv_vpn = v;
      @(posedge clk);
      idx = mfind(v);
      if (idx >= 0) m_v[idx] = 0;
      #1 idle();
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < known.size(); i++) look(known[i], 2'b00, req);
   endtask

   function automatic logic [19:0] pv(input int i);
      return 20'h01000 + 20'(i * 'h111);
   endfunction

   bit done = 0;
   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_st[i] = 0; m_tag[i] = 0; m_ppn[i] = 0; m_p[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: empty after reset
      for (int i = 0; i < 4; i++) look(pv(i), 2'(i), "R1");

      // fill to capacity with varied permissions; R6 lowest empty first
      for (int i = 0; i < N; i++)
         fill(pv(i), 20'hA0000 + 20'(i * 3), {1'b1, i[0], i[1], i[2]});
      // R2 R7 R8: every entry under every access code
      for (int i = 0; i < N; i++)
         for (int k = 0; k < 4; k++) look(pv(i), 2'(k), "R8");
      for (int i = 0; i < N; i++) look(pv(i), 2'b00, "R2");

      // R6: make entry 5 the least recently used, then evict
      for (int i = N - 1; i >= 0; i--) if (i != 5) look(pv(i), 2'b00, "R6");
      fill(20'hFFFFF, 20'h12345, 4'b1101);
      look(pv(5), 2'b00, "R6");
      look(20'hFFFFF, 2'b10, "R6");
      sweep("R6");

      // R7 R11: store to a clean writable page stays a miss, then refill dirty
      fill(20'h0ABCD, 20'h00042, 4'b1100);
      look(20'h0ABCD, 2'b01, "R7");
      look(20'h0ABCD, 2'b01, "R11");
      look(20'h0ABCD, 2'b00, "R11");
      fill(20'h0ABCD, 20'h00043, 4'b1101);
      look(20'h0ABCD, 2'b01, "R5");
      look(20'h0ABCD, 2'b01, "R11");

      // R10: invalidate absent page changes nothing; present page goes
      inval(20'h77777);
      sweep("R10");
      inval(pv(3));
      inval(pv(9));
      look(pv(3), 2'b00, "R10");
      sweep("R10");
      // R5: single copy after overwrite vanishes with one invalidate
      inval(20'h0ABCD);
      look(20'h0ABCD, 2'b00, "R5");
      // R6: empties reused lowest index first, later evictions by age
      fill(20'h20000, 20'h00100, 4'b1010);
      fill(20'h20001, 20'h00101, 4'b1010);
      fill(20'h20002, 20'h00102, 4'b1010);
      fill(20'h20003, 20'h00103, 4'b1010);
      sweep("R6");

      // R4: fill not visible in its own cycle, visible next cycle
      @(negedge clk);
      fill_valid = 1; fill_vpn = 20'h30000; fill_ppn = 20'h00777;
      {fill_rd, fill_wr, fill_ex, fill_dirty} = 4'b1000;
      lk_valid = 1; lk_vpn = 20'h30000; lk_kind = 2'b00;
      #1 check(!lk_hit && walk_req, "R4", {62'd0, lk_hit, walk_req}, 64'd1);
      @(posedge clk);
      begin
         int idx;
         idx = mvictim();
         m_v[idx] = 1; m_tag[idx] = 20'h30000; m_ppn[idx] = 20'h00777; m_p[idx] = 4'b1000; m_st[idx] = ++now;
         known.push_back(20'h30000);
      end
      #1 idle();
      look(20'h30000, 2'b11, "R4");
      sweep("R4");

      // R9: flush overrides a same-cycle fill
      @(negedge clk);
      base_chg = 1; fill_valid = 1; fill_vpn = 20'h40000; fill_ppn = 20'h00999;
      {fill_rd, fill_wr, fill_ex, fill_dirty} = 4'b1111;
      @(posedge clk);
      for (int i = 0; i < N; i++) m_v[i] = 0;
      known.push_back(20'h40000);
      #1 idle();
      sweep("R9");
      // refill after flush works again
      fill(20'h40000, 20'h00999, 4'b1111);
      look(20'h40000, 2'b01, "R4");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule